// File: doc/BRIEF.md
# Fully Associative Translation Buffer With Use and Modify Tracking

This block holds a small set of recently used page translations and maps a virtual address to a physical address. Each slot keeps a virtual page number, a physical page number, two permission flags (writable and supervisor-only), and two status flags. The referenced flag records use and the modified (dirty) flag records a write. A lookup compares the requested page against every slot at once. The result is combinational in the cycle of the request, so a hit costs no extra cycle. A lookup that finds no slot raises a miss exception in that same cycle, which lets the requester cancel the access before any register is written. A lookup that finds a slot but breaks its permissions raises a protection fault instead.

A table walker or a supervisor handler installs translations through a refill port. Only a supervisor-mode refill takes effect. If the page is already present, the refill overwrites that slot. Otherwise a victim is chosen in this order: the lowest free slot, then the lowest slot whose referenced flag is clear, then a rotating pointer. While a refill is applied, the block shows the state of the slot it is about to replace, so the replaced slot's status can be written back to the page table. A supervisor clear-referenced strobe ages every slot at once for approximate least-recently-used replacement. A flush strobe drops every translation.

Top module: `tlb_fa`

## Requirements
- R1: When `lk_valid` is high and a valid slot holds the virtual page `lk_vaddr[VA_W-1:OFF_W]` with permissions met, `lk_hit` is 1 in the same cycle. `lk_paddr` is then the slot's physical page number in bits `[PA_W-1:OFF_W]` and `lk_vaddr[OFF_W-1:0]` in the low bits.
- R2: When `lk_valid` is high and no valid slot holds the page, `lk_miss` is 1 in that same cycle, and `lk_hit`, `lk_prot_fault` and `lk_paddr` are 0. With `lk_valid` low, all three flags are 0.
- R3: A matching lookup raises `lk_prot_fault`, with `lk_hit` at 0 and `lk_paddr` at 0, in either of two cases: `lk_write`=1 and the slot is not writable, or `lk_super`=0 and the slot is supervisor-only. A fault leaves the referenced and dirty flags unchanged.
- R4: Every hit sets the hit slot's referenced flag to 1.
- R5: A hit with `lk_write`=1 sets the hit slot's dirty flag to 1.
- R6: A refill with `rf_valid`=1 and `rf_super`=1 takes effect at the clock edge. It installs a slot with referenced=0 and dirty=0. A lookup of that page in the same cycle still sees the old contents, and a lookup in the following cycle sees the new slot. If the page is already present, that slot is overwritten.
- R7: A refill with `rf_super`=0, and a clear with `clr_super`=0, change nothing.
- R8: A refill of an absent page picks its victim in priority order: the lowest-index invalid slot, then the lowest-index slot with referenced=0, then a rotating pointer. The pointer starts at 0 and advances by one, modulo `NUM_ENTRIES`, only when it is used. During an applied refill, `ev_valid` shows whether the victim slot is valid. When it is, `ev_vpn`, `ev_ref` and `ev_dirty` show the victim's page and flags. Otherwise all four are 0.
- R9: A clear with `clr_ref`=1 and `clr_super`=1 clears every referenced flag at the edge. A hit in the same cycle still sets its own slot's flag.
- R10: `flush`=1 invalidates every slot at the edge. A refill in the same cycle is discarded, shows nothing on the `ev_*` outputs, and does not move the pointer.
- R11: After reset, every slot is invalid and the rotating pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_write | input | 1 | 1 = write access, 0 = read |
| lk_super | input | 1 | 1 = supervisor mode, 0 = user mode |
| lk_paddr | output | PA_W | Translated physical address (0 unless hit) |
| lk_hit | output | 1 | Translation found and permitted |
| lk_miss | output | 1 | Miss exception, same cycle as the request |
| lk_prot_fault | output | 1 | Permission violation on a matching slot |
| rf_valid | input | 1 | Refill request |
| rf_super | input | 1 | Privilege of the refill requester |
| rf_vpn | input | VPN_W | Virtual page to install |
| rf_ppn | input | PPN_W | Physical page to install |
| rf_writable | input | 1 | Page may be written |
| rf_sup_only | input | 1 | Page reachable only in supervisor mode |
| clr_ref | input | 1 | Clear all referenced flags |
| clr_super | input | 1 | Privilege of the clear requester |
| flush | input | 1 | Invalidate all slots |
| ev_valid | output | 1 | Refill victim slot currently holds a translation |
| ev_vpn | output | VPN_W | Victim page number |
| ev_ref | output | 1 | Victim referenced flag |
| ev_dirty | output | 1 | Victim dirty flag |

## Verification
The bench runs several kinds of lookup. Cold lookups and lookups of absent pages separate a miss from a stale match. Reads across all sixteen filled slots with distinct offsets show that every comparator and the offset path work. Writes and user-mode reads against pages with mixed permissions separate a fault from a hit. Refills timed against lookups of the same page show whether the new slot appears one cycle later and not earlier. Refill sequences are arranged so the victim comes from each branch in turn: free slot, cold slot, rotating pointer, and existing page. Each victim's reported flags expose the referenced and dirty history. A randomized phase over a narrow page range mixes all strobes, including flush and clear together with refills and hits, against the cycle model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    // Where the refill victim came from
    typedef enum logic [1:0] {
        VIC_MATCH = 2'd0,  // page already present: overwrite in place
        VIC_FREE  = 2'd1,  // lowest invalid slot
        VIC_COLD  = 2'd2,  // lowest slot with referenced flag clear
        VIC_ROUND = 2'd3   // rotating pointer
    } vic_src_e;

    // Outcome of a lookup
    typedef enum logic [1:0] {
        LK_IDLE  = 2'd0,
        LK_HIT   = 2'd1,
        LK_MISS  = 2'd2,
        LK_FAULT = 2'd3
    } lk_outcome_e;

endpackage

// File: rtl/tlb_prio_enc.sv
module tlb_prio_enc #(
    parameter int N     = 16,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // Lowest set index wins
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int N     = 16,
    parameter int TAG_W = 20,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]            valid,
    input  logic [N-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]        key,
    output logic [N-1:0]            match,
    output logic                    any,
    output logic [IDX_W-1:0]        idx
);

    // One comparator per slot, all in parallel
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g] == key);
    end

    tlb_prio_enc #(.N(N), .IDX_W(IDX_W)) enc_i (
        .req   (match),
        .found (any),
        .idx   (idx)
    );

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
    import tlb_pkg::*;
#(
    parameter int N     = 16,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     valid,
    input  logic [N-1:0]     refd,
    input  logic [IDX_W-1:0] rr_ptr,
    input  logic             present,
    input  logic [IDX_W-1:0] present_idx,
    output logic [IDX_W-1:0] sel,
    output vic_src_e         src
);

    logic             free_found;
    logic [IDX_W-1:0] free_idx;
    logic             cold_found;
    logic [IDX_W-1:0] cold_idx;
    logic [N-1:0]     cold_req;

    assign cold_req = valid & ~refd;

    tlb_prio_enc #(.N(N), .IDX_W(IDX_W)) free_enc_i (
        .req   (~valid),
        .found (free_found),
        .idx   (free_idx)
    );

    tlb_prio_enc #(.N(N), .IDX_W(IDX_W)) cold_enc_i (
        .req   (cold_req),
        .found (cold_found),
        .idx   (cold_idx)
    );

    always_comb begin
        if (present) begin
            src = VIC_MATCH;
        end else if (free_found) begin
            src = VIC_FREE;
        end else if (cold_found) begin
            src = VIC_COLD;
        end else begin
            src = VIC_ROUND;
        end
    end

    always_comb begin
        unique case (src)
            VIC_MATCH: sel = present_idx;
            VIC_FREE:  sel = free_idx;
            VIC_COLD:  sel = cold_idx;
            VIC_ROUND: sel = rr_ptr;
            default:   sel = '0;
        endcase
    end

endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int VA_W        = 32,
    parameter int PA_W        = 32,
    parameter int OFF_W       = 12,
    localparam int VPN_W      = VA_W - OFF_W,
    localparam int PPN_W      = PA_W - OFF_W,
    localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic             lk_write,
    input  logic             lk_super,
    output logic [PA_W-1:0]  lk_paddr,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic             lk_prot_fault,
    input  logic             rf_valid,
    input  logic             rf_super,
    input  logic [VPN_W-1:0] rf_vpn,
    input  logic [PPN_W-1:0] rf_ppn,
    input  logic             rf_writable,
    input  logic             rf_sup_only,
    input  logic             clr_ref,
    input  logic             clr_super,
    input  logic             flush,
    output logic             ev_valid,
    output logic [VPN_W-1:0] ev_vpn,
    output logic             ev_ref,
    output logic             ev_dirty
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

    // Slot state
    logic [NUM_ENTRIES-1:0]            e_valid, n_valid;
    logic [NUM_ENTRIES-1:0]            e_ref,   n_ref;
    logic [NUM_ENTRIES-1:0]            e_dirty, n_dirty;
    logic [NUM_ENTRIES-1:0]            e_wr,    n_wr;
    logic [NUM_ENTRIES-1:0]            e_so,    n_so;
    logic [NUM_ENTRIES-1:0][VPN_W-1:0] e_vpn,   n_vpn;
    logic [NUM_ENTRIES-1:0][PPN_W-1:0] e_ppn,   n_ppn;
    logic [IDX_W-1:0]                  rr_ptr,  n_rr_ptr;

    // Lookup side
    logic [VPN_W-1:0]       lk_vpn;
    logic [OFF_W-1:0]       lk_off;
    logic [NUM_ENTRIES-1:0] lk_match;
    logic                   lk_any;
    logic [IDX_W-1:0]       lk_idx;
    logic                   perm_bad;
    lk_outcome_e            outcome;

    // Refill side
    logic [NUM_ENTRIES-1:0] rf_match;
    logic                   rf_any;
    logic [IDX_W-1:0]       rf_idx;
    logic [IDX_W-1:0]       vsel;
    vic_src_e               vsrc;
    logic                   refill_en;
    logic                   clr_en;

    assign lk_vpn    = lk_vaddr[VA_W-1:OFF_W];
    assign lk_off    = lk_vaddr[OFF_W-1:0];
    assign refill_en = rf_valid && rf_super && !flush;
    assign clr_en    = clr_ref && clr_super;

    tlb_cam #(.N(NUM_ENTRIES), .TAG_W(VPN_W), .IDX_W(IDX_W)) lk_cam_i (
        .valid (e_valid),
        .tags  (e_vpn),
        .key   (lk_vpn),
        .match (lk_match),
        .any   (lk_any),
        .idx   (lk_idx)
    );

    tlb_cam #(.N(NUM_ENTRIES), .TAG_W(VPN_W), .IDX_W(IDX_W)) rf_cam_i (
        .valid (e_valid),
        .tags  (e_vpn),
        .key   (rf_vpn),
        .match (rf_match),
        .any   (rf_any),
        .idx   (rf_idx)
    );

    tlb_victim #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) victim_i (
        .valid       (e_valid),
        .refd        (e_ref),
        .rr_ptr      (rr_ptr),
        .present     (rf_any),
        .present_idx (rf_idx),
        .sel         (vsel),
        .src         (vsrc)
    );

    // Permission check on the matched slot
    assign perm_bad = (lk_write && !e_wr[lk_idx]) || (!lk_super && e_so[lk_idx]);

    always_comb begin
        if (!lk_valid) begin
            outcome = LK_IDLE;
        end else if (!lk_any) begin
            outcome = LK_MISS;
        end else if (perm_bad) begin
            outcome = LK_FAULT;
        end else begin
            outcome = LK_HIT;
        end
    end

    // Output process
    always_comb begin
        lk_hit        = 1'b0;
        lk_miss       = 1'b0;
        lk_prot_fault = 1'b0;
        lk_paddr      = '0;
        unique case (outcome)
            LK_IDLE:  ;
            LK_HIT: begin
                lk_hit   = 1'b1;
                lk_paddr = {e_ppn[lk_idx], lk_off};
            end
            LK_MISS:  lk_miss       = 1'b1;
            LK_FAULT: lk_prot_fault = 1'b1;
            default:  ;
        endcase

        ev_valid = refill_en && e_valid[vsel];
        ev_vpn   = ev_valid ? e_vpn[vsel]   : '0;
        ev_ref   = ev_valid ? e_ref[vsel]   : 1'b0;
        ev_dirty = ev_valid ? e_dirty[vsel] : 1'b0;
    end

    // Next-state: clear, then hit update, then refill, then flush
    always_comb begin
        n_valid  = e_valid;
        n_ref    = e_ref;
        n_dirty  = e_dirty;
        n_wr     = e_wr;
        n_so     = e_so;
        n_vpn    = e_vpn;
        n_ppn    = e_ppn;
        n_rr_ptr = rr_ptr;

        if (clr_en) begin
            n_ref = '0;
        end

        if (outcome == LK_HIT) begin
            n_ref[lk_idx] = 1'b1;
            if (lk_write) begin
                n_dirty[lk_idx] = 1'b1;
            end
        end

        if (refill_en) begin
            n_valid[vsel] = 1'b1;
            n_vpn[vsel]   = rf_vpn;
            n_ppn[vsel]   = rf_ppn;
            n_wr[vsel]    = rf_writable;
            n_so[vsel]    = rf_sup_only;
            n_ref[vsel]   = 1'b0;
            n_dirty[vsel] = 1'b0;
            if (vsrc == VIC_ROUND) begin
                n_rr_ptr = (rr_ptr == LAST_IDX) ? '0 : rr_ptr + 1'b1;
            end
        end

        if (flush) begin
            n_valid = '0;
        end
    end

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_valid <= '0;
            e_ref   <= '0;
            e_dirty <= '0;
            e_wr    <= '0;
            e_so    <= '0;
            e_vpn   <= '0;
            e_ppn   <= '0;
            rr_ptr  <= '0;
        end else begin
            e_valid <= n_valid;
            e_ref   <= n_ref;
            e_dirty <= n_dirty;
            e_wr    <= n_wr;
            e_so    <= n_so;
            e_vpn   <= n_vpn;
            e_ppn   <= n_ppn;
            rr_ptr  <= n_rr_ptr;
        end
    end

    // Assertions
    assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lk_hit, lk_miss, lk_prot_fault}));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !(lk_hit || lk_miss || lk_prot_fault));

    assert_refill_visible_R6: assert property (@(posedge clk) disable iff (!rst_n)
        refill_en |=> !(lk_valid && lk_miss && (lk_vaddr[VA_W-1:OFF_W] == $past(rf_vpn))));

    assert_ref_on_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && !(refill_en && vsel == lk_idx)) |=> e_ref[$past(lk_idx)]);

    assert_dirty_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && lk_write && !(refill_en && vsel == lk_idx)) |=> e_dirty[$past(lk_idx)]);

    assert_user_refill_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_valid && !rf_super && !flush) |=> $stable(e_valid));

    assert_victim_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_en && !rf_any && !(&e_valid)) |-> !e_valid[vsel]);

    assert_flush_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (e_valid == '0));

endmodule

// File: tb/tlb_fa_tb.sv
module tlb_fa_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 16;
    localparam int VA_W       = 32;
    localparam int PA_W       = 32;
    localparam int OFF_W      = 12;
    localparam int VPN_W      = VA_W - OFF_W;
    localparam int PPN_W      = PA_W - OFF_W;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             lk_valid, lk_write, lk_super;
    logic [VA_W-1:0]  lk_vaddr;
    logic [PA_W-1:0]  lk_paddr;
    logic             lk_hit, lk_miss, lk_prot_fault;
    logic             rf_valid, rf_super, rf_writable, rf_sup_only;
    logic [VPN_W-1:0] rf_vpn;
    logic [PPN_W-1:0] rf_ppn;
    logic             clr_ref, clr_super, flush;
    logic             ev_valid, ev_ref, ev_dirty;
    logic [VPN_W-1:0] ev_vpn;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tlb_fa #(.NUM_ENTRIES(N), .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_write(lk_write), .lk_super(lk_super),
        .lk_paddr(lk_paddr), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_prot_fault(lk_prot_fault),
        .rf_valid(rf_valid), .rf_super(rf_super), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn),
        .rf_writable(rf_writable), .rf_sup_only(rf_sup_only),
        .clr_ref(clr_ref), .clr_super(clr_super), .flush(flush),
        .ev_valid(ev_valid), .ev_vpn(ev_vpn), .ev_ref(ev_ref), .ev_dirty(ev_dirty)
    );

    // Behavioural model state
    int    m_valid[N], m_vpn[N], m_ppn[N], m_wr[N], m_so[N], m_ref[N], m_dirty[N];
    int    m_rr;
    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    done   = 0;
    string cur_tag = "R11";

    task automatic chk(string field, longint got, longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", cur_tag, field, got, exp);
        end
    endtask

    task automatic clear_inputs();
        lk_valid = 0; lk_vaddr = '0; lk_write = 0; lk_super = 0;
        rf_valid = 0; rf_super = 0; rf_vpn = '0; rf_ppn = '0;
        rf_writable = 0; rf_sup_only = 0;
        clr_ref = 0; clr_super = 0; flush = 0;
    endtask

    task automatic set_lk(int vpn, int off, bit wr, bit sup);
        lk_valid = 1;
        lk_vaddr = {VPN_W'(vpn), OFF_W'(off)};
        lk_write = wr;
        lk_super = sup;
    endtask

    task automatic set_rf(int vpn, int ppn, bit wr, bit so, bit sup);
        rf_valid = 1; rf_vpn = VPN_W'(vpn); rf_ppn = PPN_W'(ppn);
        rf_writable = wr; rf_sup_only = so; rf_super = sup;
    endtask

    // One clock: compare outputs against the model, advance the model
    task automatic tick();
        int  mi, vs, vpn, off;
        bit  bad, e_hit, e_miss, e_flt, ren, round, e_evv;
        longint e_pa;
        #2;
        vpn = int'(lk_vaddr[VA_W-1:OFF_W]);
        off = int'(lk_vaddr[OFF_W-1:0]);
        mi = -1;
        for (int i = 0; i < N; i++) if (m_valid[i] != 0 && m_vpn[i] == vpn) mi = i;
        bad    = (mi >= 0) && ((lk_write && m_wr[mi] == 0) || (!lk_super && m_so[mi] != 0));
        e_hit  = lk_valid && mi >= 0 && !bad;
        e_miss = lk_valid && mi < 0;
        e_flt  = lk_valid && mi >= 0 && bad;
        e_pa   = e_hit ? ((longint'(m_ppn[mi]) << OFF_W) | longint'(off)) : 0;

        ren = rf_valid && rf_super && !flush;
        round = 0;
        vs = -1;
        for (int i = 0; i < N; i++) if (vs < 0 && m_valid[i] != 0 && m_vpn[i] == int'(rf_vpn)) vs = i;
        for (int i = 0; i < N; i++) if (vs < 0 && m_valid[i] == 0) vs = i;
        for (int i = 0; i < N; i++) if (vs < 0 && m_ref[i] == 0) vs = i;
        if (vs < 0) begin vs = m_rr; round = 1; end
        e_evv = ren && m_valid[vs] != 0;

        chk("lk_hit", lk_hit, e_hit);
        chk("lk_miss", lk_miss, e_miss);
        chk("lk_prot_fault", lk_prot_fault, e_flt);
        chk("lk_paddr", lk_paddr, e_pa);
        chk("ev_valid", ev_valid, e_evv);
        chk("ev_vpn", ev_vpn, e_evv ? m_vpn[vs] : 0);
        chk("ev_ref", ev_ref, e_evv ? m_ref[vs] : 0);
        chk("ev_dirty", ev_dirty, e_evv ? m_dirty[vs] : 0);

        if (clr_ref && clr_super) for (int i = 0; i < N; i++) m_ref[i] = 0;
        if (e_hit) begin
            m_ref[mi] = 1;
            if (lk_write) m_dirty[mi] = 1;
        end
        if (ren) begin
            m_valid[vs] = 1; m_vpn[vs] = int'(rf_vpn); m_ppn[vs] = int'(rf_ppn);
            m_wr[vs] = rf_writable; m_so[vs] = rf_sup_only;
            m_ref[vs] = 0; m_dirty[vs] = 0;
            if (round) m_rr = (m_rr + 1) % N;
        end
        if (flush) for (int i = 0; i < N; i++) m_valid[i] = 0;

        @(negedge clk);
        cycles++;
        clear_inputs();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0; m_wr[i] = 0;
            m_so[i] = 0; m_ref[i] = 0; m_dirty[i] = 0;
        end
        m_rr = 0;
        clear_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R11: reset state, page 0 must miss (no stale valid slot)
        cur_tag = "R11";
        tick();
        set_lk(0, 0, 0, 1); tick();

        // R2: miss on an absent page
        cur_tag = "R2";
        set_lk('h123, 'h10, 0, 1); tick();

        // R7: user refill ignored, page still absent
        cur_tag = "R7";
        set_rf('h123, 'h0AB, 1, 0, 0); tick();
        set_lk('h123, 0, 0, 1); tick();

        // R6: same-cycle lookup sees the old state, next cycle hits
        cur_tag = "R6";
        set_rf('h123, 'h0AB, 1, 0, 1); set_lk('h123, 4, 0, 1); tick();
        set_lk('h123, 'h456, 0, 1); tick();

        // R1: fill the remaining slots, read each with its own offset
        cur_tag = "R1";
        for (int i = 1; i < N; i++) begin
            set_rf('h200 + i, 'h300 + i, i % 2, (i % 3) == 0, 1); tick();
        end
        for (int i = 1; i < N; i++) begin
            set_lk('h200 + i, i * 'h11, 0, 1); tick();
        end

        // R3: write to a read-only page; user access to a supervisor page
        cur_tag = "R3";
        set_lk('h202, 0, 1, 1); tick();
        set_lk('h203, 0, 0, 0); tick();
        set_lk('h201, 8, 0, 0); tick();

        // R5: write hit marks the page modified
        cur_tag = "R5";
        set_lk('h201, 'hFFF, 1, 0); tick();

        // R8: all valid and referenced, so the pointer picks slot 0
        cur_tag = "R8";
        set_rf('h400, 'h500, 1, 0, 1); tick();
        // freshly installed slot 0 is cold, so it is picked again
        set_rf('h401, 'h501, 1, 0, 1); tick();

        // R4: a hit warms slot 0; pointer then evicts slot 1 (dirty, referenced)
        cur_tag = "R4";
        set_lk('h401, 0, 0, 1); tick();
        cur_tag = "R7";
        clr_ref = 1; clr_super = 0; tick();
        cur_tag = "R4";
        set_rf('h402, 'h502, 1, 0, 1); tick();

        // R9: supervisor clear together with a hit on slot 1
        cur_tag = "R9";
        clr_ref = 1; clr_super = 1; set_lk('h402, 0, 0, 1); tick();
        set_rf('h403, 'h503, 1, 0, 1); tick();
        set_lk('h403, 0, 0, 1); tick();
        set_rf('h405, 'h505, 1, 0, 1); tick();

        // R6: refill of a present page overwrites it in place
        cur_tag = "R6";
        set_rf('h204, 'h777, 1, 0, 1); tick();
        set_lk('h204, 'h21, 0, 1); tick();

        // R10: flush wins over a refill in the same cycle
        cur_tag = "R10";
        flush = 1; set_rf('h500, 'h600, 1, 0, 1); tick();
        set_lk('h500, 0, 0, 1); tick();
        set_lk('h204, 0, 0, 1); tick();
        set_rf('h600, 'h601, 1, 1, 1); tick();

        // Mixed random traffic over a narrow page range
        cur_tag = "R1";
        for (int k = 0; k < 2000; k++) begin
            if ($urandom_range(0, 3) != 0) set_lk($urandom_range(0, 24), $urandom_range(0, 4095),
                                                 $urandom_range(0, 1), $urandom_range(0, 1));
            if ($urandom_range(0, 2) == 0) set_rf($urandom_range(0, 24), $urandom_range(0, 'hFFFF),
                                                 $urandom_range(0, 1), $urandom_range(0, 1),
                                                 $urandom_range(0, 3) != 0);
            if ($urandom_range(0, 15) == 0) begin clr_ref = 1; clr_super = $urandom_range(0, 1); end
            if ($urandom_range(0, 60) == 0) flush = 1;
            tick();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule